// File: doc/BRIEF.md
# Microcontroller Interrupt Control Unit

This block gathers interrupt requests from seven sources in a small 8-bit microcontroller and tells the core when to take an interrupt. The sources are an external pin edge, a port change, a timer-0 overflow, a timer-1 overflow, a comparator change, an A/D conversion done and an EEPROM write done. Each source arrives as a one-cycle event pulse from its peripheral or synchronizer.

Three registers sit on a small register port:
- The core control register holds the global enable, a gate for the peripheral group, and the enables and flags of the three core sources.
- The peripheral flag register holds the four peripheral flags.
- The peripheral enable register holds their four enables.

The core supplies a strobe at each instruction-cycle boundary. When an interrupt is taken, the unit raises a one-cycle take pulse and a push request, and it presents the fixed vector 0x0004. At that point it clears the global enable. The core's return-from-interrupt pulse sets the global enable again.

Top module: `intc_unit`

## Requirements
- R1: After reset, all three registers read 0x00 and the take output is 0.
- R2: A source event sets that source's flag on the next clock, whatever the state of its enable, the peripheral gate and the global enable.
- R3: When a source event and a register write of 0 to the same flag occur in the same cycle, the flag ends up set.
- R4: The take output is a one-cycle pulse. It rises on the clock edge that ends a strobe cycle in which the global enable is 1 and at least one source is pending. Without a strobe, no take occurs.
- R5: A core source is pending when its flag and its enable are both 1. A peripheral source also needs the peripheral gate to be 1.
- R6: While the global enable is 0, no take occurs, even with sources pending and the strobe high.
- R7: On a take, the global enable reads back 0 afterwards, the push request is high in the same cycle as the take, and the vector output equals 0x0004.
- R8: A write to the core control register with bit 7 = 0 during a strobe cycle cancels the take that would have followed. The flag stays set, and the interrupt is taken on a later strobe once the global enable is 1 again.
- R9: A return-from-interrupt pulse sets the global enable to 1 on the next clock.
- R10: Flags clear only by register writes. A flag that is still set when the global enable is restored causes another take at the next strobe.
- R11: Register map and bit layout:
  - Address 0 is the core control register: bit 7 global enable, bit 6 peripheral gate, bit 5 timer-0 enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer-0 flag, bit 1 pin flag, bit 0 port-change flag.
  - Address 1 is the peripheral flag register and address 2 is the peripheral enable register. Both use bit 0 timer-1, bit 1 comparator, bit 2 A/D, bit 3 EEPROM write, with bits 7..4 reading 0.
  - Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| ev_pin | input | 1 | External pin edge event |
| ev_port | input | 1 | Port change event |
| ev_tmr0 | input | 1 | Timer-0 overflow event |
| ev_tmr1 | input | 1 | Timer-1 overflow event |
| ev_cmp | input | 1 | Comparator event |
| ev_adc | input | 1 | A/D done event |
| ev_eew | input | 1 | EEPROM write done event |
| cyc_strobe | input | 1 | Instruction-cycle boundary strobe from the core |
| ret_int | input | 1 | Return-from-interrupt pulse from the core |
| irq_take | output | 1 | Interrupt take pulse |
| push_ret | output | 1 | Request to push the return address |
| pc_vector | output | PCW | Program-counter load value on a take |

## Verification
The bench runs a cancelling write in the same strobe cycle as a pending request. A design that samples the old global enable would fire the take anyway, and one that wiped the flag would never service the request afterwards.

It lands a pin event on the same cycle as a software write of 0 to that flag. A design that gives the write priority would lose the event.

It raises peripheral flags with the peripheral gate closed. A design that skips that gate would take early.

It restores the global enable over a flag that is still set. A design with a one-shot request would miss the repeat take that must follow.

// File: rtl/intc_unit.sv
module intc_unit #(
  parameter int              PCW = 13,
  parameter logic [PCW-1:0]  VEC = 'h0004
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     addr,
  input  logic [7:0]     wr_data,
  output logic [7:0]     rd_data,
  input  logic           ev_pin,
  input  logic           ev_port,
  input  logic           ev_tmr0,
  input  logic           ev_tmr1,
  input  logic           ev_cmp,
  input  logic           ev_adc,
  input  logic           ev_eew,
  input  logic           cyc_strobe,
  input  logic           ret_int,
  output logic           irq_take,
  output logic           push_ret,
  output logic [PCW-1:0] pc_vector
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_PFL = 2'd1;
  localparam logic [1:0] A_PEN = 2'd2;

  logic       gie, peie;
  logic [2:0] cen, cflg;
  logic [3:0] pflg, pen;

  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_pfl = wr_en && addr == A_PFL;
  wire wr_pen = wr_en && addr == A_PEN;

  wire [2:0] cev = {ev_tmr0, ev_pin, ev_port};
  wire [3:0] pev = {ev_eew, ev_adc, ev_cmp, ev_tmr1};

  wire pend     = (|(cflg & cen)) | (peie & (|(pflg & pen)));
  wire gie_drop = wr_ctl & ~wr_data[7];
  wire take_d   = cyc_strobe & gie & pend & ~gie_drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      peie     <= 1'b0;
      cen      <= '0;
      cflg     <= '0;
      pflg     <= '0;
      pen      <= '0;
      irq_take <= 1'b0;
    end else begin
      irq_take <= take_d;
      if (wr_ctl) {peie, cen} <= wr_data[6:3];
      if (wr_pen) pen <= wr_data[3:0];
      cflg <= (wr_ctl ? wr_data[2:0] : cflg) | cev;
      pflg <= (wr_pfl ? wr_data[3:0] : pflg) | pev;
      if (take_d)       gie <= 1'b0;
      else if (ret_int) gie <= 1'b1;
      else if (wr_ctl)  gie <= wr_data[7];
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_data = {gie, peie, cen, cflg};
      A_PFL:   rd_data = {4'b0, pflg};
      A_PEN:   rd_data = {4'b0, pen};
      default: rd_data = 8'h00;
    endcase
  end

  assign push_ret  = irq_take;
  assign pc_vector = VEC;
endmodule

module intc_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_strobe,
  input logic       ret_int,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wr_data,
  input logic       ev_pin,
  input logic       ev_adc,
  input logic       irq_take,
  input logic       gie,
  input logic       pin_flag,
  input logic       adc_flag
);
  // R4
  take_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(cyc_strobe));
  // R4
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  // R6
  take_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(gie));
  // R7
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !gie);
  // R8
  drop_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && wr_en && addr == 2'd0 && !wr_data[7]) |=> !irq_take);
  // R9
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_int |=> (gie || irq_take));
  // R2
  pin_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> pin_flag);
  // R2
  adc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adc |=> adc_flag);
endmodule

bind intc_unit intc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ret_int(ret_int),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .ev_pin(ev_pin),
  .ev_adc(ev_adc), .irq_take(irq_take), .gie(gie),
  .pin_flag(cflg[1]), .adc_flag(pflg[2])
);

// File: tb/intc_unit_tb.sv
module intc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        ev_pin = 0, ev_port = 0, ev_tmr0 = 0, ev_tmr1 = 0;
  logic        ev_cmp = 0, ev_adc = 0, ev_eew = 0;
  logic        cyc_strobe = 0, ret_int = 0;
  logic        irq_take, push_ret;
  logic [12:0] pc_vector;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_pin(ev_pin), .ev_port(ev_port), .ev_tmr0(ev_tmr0),
    .ev_tmr1(ev_tmr1), .ev_cmp(ev_cmp), .ev_adc(ev_adc), .ev_eew(ev_eew),
    .cyc_strobe(cyc_strobe), .ret_int(ret_int), .irq_take(irq_take),
    .push_ret(push_ret), .pc_vector(pc_vector)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic strobe();
    cyc_strobe = 1;
    step();
    cyc_strobe = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl", d, 8'h00);
    rd(1, d); chk("R1 pflag", d, 8'h00);
    rd(2, d); chk("R1 pen", d, 8'h00);
    chk("R1 take", irq_take, 0);
  endtask

  task automatic t_flags_masked();
    logic [7:0] d;
    {ev_pin, ev_port, ev_tmr0, ev_tmr1, ev_cmp, ev_adc, ev_eew} = '1;
    step();
    {ev_pin, ev_port, ev_tmr0, ev_tmr1, ev_cmp, ev_adc, ev_eew} = '0;
    rd(0, d); chk("R2 R11 core flags", d, 8'h07);
    rd(1, d); chk("R2 R11 periph flags", d, 8'h0F);
    wr(0, 8'h78);
    wr(2, 8'h0F);
    strobe();
    chk("R6 no take with gie=0", irq_take, 0);
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    rd(0, d); chk("R10 write clears flags", d, 8'h00);
  endtask

  task automatic t_event_wins();
    logic [7:0] d;
    wr(0, 8'h02);
    ev_pin = 1; wr_en = 1; addr = 0; wr_data = 8'h00;
    step();
    ev_pin = 0; wr_en = 0;
    rd(0, d); chk("R3 event beats write", d, 8'h02);
    wr(0, 8'h00);
  endtask

  task automatic t_take();
    logic [7:0] d;
    wr(0, 8'h88);
    ev_port = 1; step(); ev_port = 0;
    step();
    chk("R4 no take without strobe", irq_take, 0);
    strobe();
    chk("R4 take", irq_take, 1);
    chk("R7 push", push_ret, 1);
    chk("R7 vector", pc_vector, 13'h0004);
    step();
    chk("R4 single pulse", irq_take, 0);
    rd(0, d); chk("R7 gie cleared, flag kept", d, 8'h09);
    ret_int = 1; step(); ret_int = 0;
    rd(0, d); chk("R9 ret sets gie", d, 8'h89);
    strobe();
    chk("R10 repeat take", irq_take, 1);
    step();
    ret_int = 1; step(); ret_int = 0;
    wr(0, 8'h88);
    strobe();
    chk("R10 no take after clear", irq_take, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_cancel();
    logic [7:0] d;
    wr(0, 8'h90);
    ev_pin = 1; step(); ev_pin = 0;
    cyc_strobe = 1; wr_en = 1; addr = 0; wr_data = 8'h12;
    step();
    cyc_strobe = 0; wr_en = 0;
    chk("R8 take cancelled", irq_take, 0);
    rd(0, d); chk("R8 flag pending", d, 8'h12);
    wr(0, 8'h92);
    strobe();
    chk("R8 serviced later", irq_take, 1);
    step();
    wr(0, 8'h00);
  endtask

  task automatic t_periph();
    logic [7:0] d;
    wr(2, 8'h04);
    wr(0, 8'h80);
    ev_adc = 1; step(); ev_adc = 0;
    strobe();
    chk("R5 periph gate closed", irq_take, 0);
    wr(0, 8'hC0);
    strobe();
    chk("R5 periph take", irq_take, 1);
    step();
    rd(1, d); chk("R11 adc flag bit2", d, 8'h04);
    wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h00);
  endtask

  initial begin
    #(8 * 5000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected done");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    t_reset();
    t_flags_masked();
    t_event_wins();
    t_take();
    t_cancel();
    t_periph();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule